// File: doc/BRIEF.md
# Bounded-Error Spread-Spectrum Clock Generator

This block derives a frequency-modulated clock from a fast, fixed reference clock. It does so entirely in logic. Each output half-period lasts a nominal number of reference ticks plus a small signed offset. The offset changes from one half-period to the next, so the clock's energy is smeared over a band of frequencies rather than packed into one spectral line. Two offset sources are available: a slow triangular sweep and a pseudo-random dither drawn from a shift register.

A closed loop keeps a running total of the offsets applied so far. That total is the signed distance, in reference ticks, between the latest modulated edge and the place an unmodulated divide-by-nominal clock would have put it. Before each half-period starts, the loop checks whether the requested offset would push this distance past a fixed bound. If it would, the loop overrides the request and steps the error back toward zero. The bound is set from a time budget and the reference frequency: 20 ns at 200 MHz gives 4 ticks. This keeps every edge close enough to its ideal position that timing-sensitive consumers, such as serial links, see no disturbance.

When enable is low, the block behaves as an exact divider and reports zero phase error.

Top module: `spread_clk_gen`

## Requirements
- R1: While reset is high, and on the first sample after it, clkOut is low, edgeStb is low and phaseErr is zero.
- R2: With enable low, clkOut changes level every nomHalf reference ticks exactly. phaseErr reads zero from the cycle after enable is sampled low.
- R3: edgeStb is high for exactly the one cycle in which clkOut first shows a new level, and it is low in every other cycle.
- R4: Take the first clkOut edge after enable rises as the anchor; it reports phaseErr zero. At the k-th edge after the anchor, phaseErr equals the actual edge time minus (anchor time + k·nomHalf), in reference ticks.
- R5: The magnitude of phaseErr never exceeds MAX_ERR = ERR_NS·REF_MHZ/1000 ticks (4 at default parameters).
- R6: If adding the requested offset would take the error past MAX_ERR, the offset actually applied is one tick toward zero error (zero if the error is zero). In sweep mode the bound is therefore reached and held, but never crossed.
- R7: With modeSel = 1 (dither), a 16-bit Galois shift register (mask 0xB400, advanced once per output edge) picks each offset from its two low bits: 00 gives -1, 10 gives +1, and anything else gives 0. Half-periods are therefore nomHalf-1, nomHalf or nomHalf+1, and both the longer and the shorter lengths occur.
- R8: With modeSel = 0 (sweep), the offset ramps by one tick every RATE_DIV output edges between -DEPTH and +DEPTH and reverses at each end. Half-periods stay within nomHalf±DEPTH, and both longer and shorter ones occur.
- R9: nomHalf is sampled at every output edge and must be at least DEPTH+2. The smallest legal setting still produces a correctly bounded clock.
- R10: Dropping enable mid-run clears the error at once. The half-period already in progress finishes, and every half-period after it is exactly nomHalf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Modulation on when high; exact divider when low |
| modeSel | input | 1 | 0 = triangular sweep, 1 = pseudo-random dither |
| nomHalf | input | NOM_W | Nominal half-period in reference ticks |
| clkOut | output | 1 | Modulated output clock |
| edgeStb | output | 1 | One-cycle pulse marking each clkOut level change |
| phaseErr | output | ERR_W | Signed tick offset of the latest edge from its ideal position |

## Verification
The bench keeps its own ideal edge grid and compares every modulated edge against it. A design that accumulated the wrong offset, or updated the error one edge late, would report a phaseErr that disagrees with the measured drift. A design with an off-by-one in the clamp would let the drift reach MAX_ERR+1.

Several other faults are targeted:
- A weakened clamp is caught in sweep mode, where the bound is pressed constantly, and the bench requires the bound to be reached exactly.
- Dropping enable mid-run checks that the error clears at once and that the output falls back to exact nominal lengths. A design that kept stale offsets would produce irregular half-periods.
- Running at the minimum legal nomHalf exposes counter underflow at the shortest reloads.
- Watching the strobe against clkOut catches a strobe that is misaligned by one cycle.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  // Fixed width of the per-half-period offset carried from control to datapath.
  localparam int ADJ_W = 8;

  typedef enum logic {
    MODE_SWEEP  = 1'b0,
    MODE_DITHER = 1'b1
  } modSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                    reload;  // start a new half-period this cycle
    logic signed [ADJ_W-1:0] adj;     // signed tick offset for that half-period
  } dpCmd_t;

endpackage

// File: rtl/sscg_ramp.sv
module sscg_ramp #(
  parameter int DEPTH    = 3,
  parameter int RATE_DIV = 32,
  parameter int ADJ_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic signed [ADJ_W-1:0] rampVal
);

  localparam int PRE_W = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;
  localparam logic signed [ADJ_W-1:0] RAMP_TOP = ADJ_W'(DEPTH);
  localparam logic signed [ADJ_W-1:0] RAMP_BOT = -RAMP_TOP;

  logic [PRE_W-1:0] preCnt;
  logic             goingUp;
  logic             preWrap;

  assign preWrap = (preCnt == PRE_W'(RATE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      goingUp <= 1'b1;
      rampVal <= '0;
    end else if (step) begin
      if (preWrap) begin
        preCnt <= '0;
        if (goingUp) begin
          if (rampVal >= RAMP_TOP) begin
            goingUp <= 1'b0;
            rampVal <= rampVal - ADJ_W'(1);
          end else begin
            rampVal <= rampVal + ADJ_W'(1);
          end
        end else begin
          if (rampVal <= RAMP_BOT) begin
            goingUp <= 1'b1;
            rampVal <= rampVal + ADJ_W'(1);
          end else begin
            rampVal <= rampVal - ADJ_W'(1);
          end
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  a_r8_ramp_range: assert property (@(posedge clk) disable iff (rst)
    (rampVal <= RAMP_TOP) && (rampVal >= RAMP_BOT));

  a_r8_ramp_slew: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rampVal == $past(rampVal)) ||
             (rampVal == $past(rampVal) + ADJ_W'(1)) ||
             (rampVal == $past(rampVal) - ADJ_W'(1)));

  a_r8_ramp_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rampVal));

endmodule

// File: rtl/sscg_lfsr.sv
module sscg_lfsr #(
  parameter int             W     = 16,
  parameter logic [W-1:0]   TAPS  = 16'hB400,
  parameter logic [W-1:0]   SEED  = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  output logic [1:0] lfsrPick
);

  logic [W-1:0] state;
  logic [W-1:0] nxt;

  // Galois right-shift form: each bit takes its upper neighbour, XORed with
  // the outgoing bit wherever the mask has a one.
  for (genvar i = 0; i < W - 1; i++) begin : g_tap
    assign nxt[i] = state[i+1] ^ (TAPS[i] & state[0]);
  end
  assign nxt[W-1] = TAPS[W-1] & state[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (step) begin
      state <= nxt;
    end
  end

  assign lfsrPick = state[1:0];

  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  a_r7_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));

endmodule

// File: rtl/sscg_ctrl.sv
module sscg_ctrl
  import sscg_pkg::*;
#(
  parameter int DEPTH   = 3,
  parameter int MAX_ERR = 4,
  parameter int ERR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    modeSel,
  input  logic                    tickLast,
  input  logic signed [ADJ_W-1:0] rampVal,
  input  logic [1:0]              lfsrPick,
  output dpCmd_t                  cmd,
  output logic signed [ERR_W-1:0] phaseErr
);

  localparam int SUM_W = ((ERR_W > ADJ_W) ? ERR_W : ADJ_W) + 2;
  localparam logic signed [SUM_W-1:0] LIM = SUM_W'(MAX_ERR);

  logic signed [ERR_W-1:0] errQ;      // error at the latest completed edge
  logic signed [ADJ_W-1:0] runAdj;    // offset of the half-period now running
  logic signed [ADJ_W-1:0] reqAdj;
  logic signed [ADJ_W-1:0] applied;
  logic signed [SUM_W-1:0] errAfter;  // error at the edge being produced now
  logic signed [SUM_W-1:0] trial;
  logic                    overBound;

  // Requested offset for the next half-period.
  always_comb begin
    reqAdj = '0;
    if (enable) begin
      if (modeSel == MODE_DITHER) begin
        unique case (lfsrPick)
          2'b00:   reqAdj = '1;            // -1
          2'b10:   reqAdj = ADJ_W'(1);     // +1
          default: reqAdj = '0;
        endcase
      end else begin
        reqAdj = rampVal;
      end
    end
  end

  // Closed-loop clamp.
  always_comb begin
    errAfter  = SUM_W'(errQ) + SUM_W'(runAdj);
    trial     = errAfter + SUM_W'(reqAdj);
    overBound = (trial > LIM) || (trial < -LIM);
    applied   = reqAdj;
    if (overBound) begin
      if (errAfter > 0) begin
        applied = '1;
      end else if (errAfter < 0) begin
        applied = ADJ_W'(1);
      end else begin
        applied = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      errQ   <= '0;
      runAdj <= '0;
    end else if (tickLast) begin
      errQ   <= ERR_W'(errAfter);
      runAdj <= applied;
    end
  end

  assign cmd.reload = tickLast;
  assign cmd.adj    = applied;
  assign phaseErr   = errQ;

  a_r5_err_bound: assert property (@(posedge clk) disable iff (rst)
    (phaseErr <= ERR_W'(MAX_ERR)) && (phaseErr >= -ERR_W'(MAX_ERR)));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (phaseErr == '0));

  a_r10_idle_nominal: assert property (@(posedge clk) disable iff (rst)
    (tickLast && !enable) |-> (cmd.adj == '0));

  a_r7_dither_unit: assert property (@(posedge clk) disable iff (rst)
    (tickLast && enable && modeSel == MODE_DITHER) |->
      ((cmd.adj == '0) || (cmd.adj == '1) || (cmd.adj == ADJ_W'(1))));

  a_r8_sweep_depth: assert property (@(posedge clk) disable iff (rst)
    tickLast |-> ((cmd.adj <= ADJ_W'(DEPTH)) && (cmd.adj >= -ADJ_W'(DEPTH))));

  a_r6_err_hold: assert property (@(posedge clk) disable iff (rst)
    (enable && !tickLast) |=> $stable(phaseErr));

endmodule

// File: rtl/sscg_dp.sv
module sscg_dp
  import sscg_pkg::*;
#(
  parameter int NOM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NOM_W-1:0] nomHalf,
  input  dpCmd_t           cmd,
  output logic             tickLast,
  output logic             clkOut,
  output logic             edgeStb
);

  localparam int CNT_W = ((NOM_W > ADJ_W) ? NOM_W : ADJ_W) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] adjExt;
  logic [CNT_W-1:0] loadVal;

  assign adjExt   = {{(CNT_W - ADJ_W){cmd.adj[ADJ_W-1]}}, cmd.adj};
  assign loadVal  = CNT_W'(nomHalf) + adjExt;
  assign tickLast = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CNT_W'(1);
      clkOut  <= 1'b0;
      edgeStb <= 1'b0;
    end else begin
      edgeStb <= cmd.reload;
      if (cmd.reload) begin
        cnt    <= loadVal;
        clkOut <= ~clkOut;
      end else begin
        cnt    <= cnt - CNT_W'(1);
      end
    end
  end

  a_r3_strobe_toggle: assert property (@(posedge clk) disable iff (rst)
    edgeStb |-> (clkOut != $past(clkOut)));

  a_r3_quiet_level: assert property (@(posedge clk) disable iff (rst)
    !edgeStb |-> (clkOut == $past(clkOut)));

  a_r9_cnt_live: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!clkOut && !edgeStb));

endmodule

// File: rtl/spread_clk_gen.sv
module spread_clk_gen
  import sscg_pkg::*;
#(
  parameter  int NOM_W     = 8,
  parameter  int REF_MHZ   = 200,
  parameter  int ERR_NS    = 20,
  parameter  int DEPTH     = 3,
  parameter  int RATE_DIV  = 32,
  parameter  logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int MAX_ERR   = ERR_NS * REF_MHZ / 1000,
  localparam int ERR_W     = $clog2(MAX_ERR + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    modeSel,
  input  logic [NOM_W-1:0]        nomHalf,
  output logic                    clkOut,
  output logic                    edgeStb,
  output logic signed [ERR_W-1:0] phaseErr
);

  dpCmd_t                  cmd;
  logic                    tickLast;
  logic signed [ADJ_W-1:0] rampVal;
  logic [1:0]              lfsrPick;

  sscg_ramp #(
    .DEPTH   (DEPTH),
    .RATE_DIV(RATE_DIV),
    .ADJ_W   (ADJ_W)
  ) ramp_i (
    .clk    (clk),
    .rst    (rst),
    .step   (tickLast),
    .rampVal(rampVal)
  );

  sscg_lfsr #(
    .W   (16),
    .TAPS(16'hB400),
    .SEED(LFSR_SEED)
  ) lfsr_i (
    .clk     (clk),
    .rst     (rst),
    .step    (tickLast),
    .lfsrPick(lfsrPick)
  );

  sscg_ctrl #(
    .DEPTH  (DEPTH),
    .MAX_ERR(MAX_ERR),
    .ERR_W  (ERR_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .modeSel (modeSel),
    .tickLast(tickLast),
    .rampVal (rampVal),
    .lfsrPick(lfsrPick),
    .cmd     (cmd),
    .phaseErr(phaseErr)
  );

  sscg_dp #(
    .NOM_W(NOM_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .nomHalf (nomHalf),
    .cmd     (cmd),
    .tickLast(tickLast),
    .clkOut  (clkOut),
    .edgeStb (edgeStb)
  );

endmodule

// File: tb/spread_clk_gen_tb_top.sv
`timescale 1ns/1ps
module spread_clk_gen_tb_top;

  localparam int REF_MHZ = 200;
  localparam int ERR_NS  = 20;
  localparam int DEPTH   = 3;
  localparam int MAXE    = ERR_NS * REF_MHZ / 1000;
  localparam int ERR_W   = $clog2(MAXE + 1) + 1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    enable = 1'b0;
  logic                    modeSel = 1'b0;
  logic [7:0]              nomHalf = 8'd10;
  logic                    clkOut;
  logic                    edgeStb;
  logic signed [ERR_W-1:0] phaseErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spread_clk_gen dut_i (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .modeSel (modeSel),
    .nomHalf (nomHalf),
    .clkOut  (clkOut),
    .edgeStb (edgeStb),
    .phaseErr(phaseErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Watches nEdges output edges. Checks strobe alignment, half-period range,
  // and either the ideal grid (trackIdeal) or a zero error (idle).
  task automatic observe(input int nEdges, input int nom, input int lo,
                         input int hi, input bit trackIdeal, input string rq,
                         output int nLong, output int nShort, output int maxAbs);
    int tick = 0;
    int lastT = -1;
    int anchor = -1;
    int k = 0;
    int seen = 0;
    int dev;
    int iv;
    logic prevClk;
    nLong = 0; nShort = 0; maxAbs = 0;
    prevClk = clkOut;
    while (seen < nEdges && tick < 40000) begin
      @(negedge clk);
      tick++;
      check((clkOut != prevClk) == edgeStb, "R3", "strobe vs level change",
            int'(edgeStb), int'(clkOut != prevClk));
      prevClk = clkOut;
      if (edgeStb) begin
        if (lastT >= 0) begin
          iv = tick - lastT;
          check(iv >= lo && iv <= hi, rq, "half-period length", iv, nom);
          if (iv > nom) nLong++;
          if (iv < nom) nShort++;
        end
        if (trackIdeal) begin
          if (anchor < 0) begin
            anchor = tick;
            check(phaseErr == 0, "R4", "anchor edge error", int'(phaseErr), 0);
          end else begin
            k++;
            dev = tick - (anchor + k * nom);
            check(int'(phaseErr) == dev, "R4", "reported vs measured drift",
                  int'(phaseErr), dev);
            check(dev <= MAXE && dev >= -MAXE, "R5", "drift bound", dev, MAXE);
            if (dev > maxAbs) maxAbs = dev;
            if (-dev > maxAbs) maxAbs = -dev;
          end
        end else begin
          check(phaseErr == 0, "R2", "idle error", int'(phaseErr), 0);
        end
        lastT = tick;
        seen++;
      end
    end
    check(seen == nEdges, rq, "edges observed", seen, nEdges);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(clkOut == 1'b0, "R1", "clkOut in reset", int'(clkOut), 0);
    check(edgeStb == 1'b0, "R1", "edgeStb in reset", int'(edgeStb), 0);
    check(phaseErr == 0, "R1", "phaseErr in reset", int'(phaseErr), 0);
    rst = 1'b0;
    @(negedge clk);
    check(phaseErr == 0, "R1", "phaseErr after release", int'(phaseErr), 0);
  endtask

  task automatic t_idle(input int nom, input string rq);
    int nl, ns, ma;
    enable = 1'b0;
    nomHalf = 8'(nom);
    @(negedge clk);
    observe(30, nom, nom, nom, 1'b0, rq, nl, ns, ma);
  endtask

  task automatic t_dither(input int nom);
    int nl, ns, ma;
    enable = 1'b0;
    @(negedge clk);
    nomHalf = 8'(nom);
    modeSel = 1'b1;
    enable = 1'b1;
    observe(600, nom, nom - 1, nom + 1, 1'b1, "R7", nl, ns, ma);
    check(nl > 0, "R7", "dither lengthened half-periods", nl, 1);
    check(ns > 0, "R7", "dither shortened half-periods", ns, 1);
  endtask

  task automatic t_sweep(input int nom, input int nEdges, input string rq);
    int nl, ns, ma;
    enable = 1'b0;
    @(negedge clk);
    nomHalf = 8'(nom);
    modeSel = 1'b0;
    enable = 1'b1;
    observe(nEdges, nom, nom - DEPTH, nom + DEPTH, 1'b1, rq, nl, ns, ma);
    check(nl > 0, "R8", "sweep lengthened half-periods", nl, 1);
    check(ns > 0, "R8", "sweep shortened half-periods", ns, 1);
    check(ma == MAXE, "R6", "bound reached but not crossed", ma, MAXE);
  endtask

  task automatic t_disable_mid(input int nom);
    int nl, ns, ma;
    enable = 1'b0;
    @(negedge clk);
    nomHalf = 8'(nom);
    modeSel = 1'b0;
    enable = 1'b1;
    repeat (400) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(phaseErr == 0, "R10", "error cleared after disable", int'(phaseErr), 0);
    observe(20, nom, nom, nom, 1'b0, "R10", nl, ns, ma);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_idle(10, "R2");
    t_idle(20, "R9");
    t_dither(10);
    t_sweep(12, 1500, "R8");
    t_sweep(DEPTH + 2, 600, "R9");
    t_disable_mid(10);
    finish_run();
  end

endmodule